// File: doc/BRIEF.md
# Memory-to-Memory Sequential Processor Core

This block is a small stored-program processor. Program and data live together in one internal word-addressed RAM. A control unit runs an endless fetch, decode and execute loop. Every RAM access goes through two registers: an address register, loaded from the program counter or from an address field of the current instruction, and a data register, which captures read data or holds the value to be written. A single fetch strobe or a single store strobe moves one whole cell at a time.

An instruction word holds an opcode and two address fields. The core can load a cell into a working register, and it can compare two cells, which sets exactly one of three condition flags. Its add instruction reads both operands from memory and writes the sum over the second operand's cell. A halt instruction stops the loop. An opcode the core does not know stops it as well, and also raises a fault output. While reset is held, an external preload port fills the RAM. A peek port reads any cell at any time. Execution begins at cell 0 once reset is released.

Top module: `mm_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `halted`, `fault`, `flags` and `workReg` are all zero. Execution starts with the instruction in cell 0.
- R2: A write on the preload port (`preWe`, `preAddr`, `preData`) lands in the RAM only while `rst` is high. While the core runs, a preload write does not change any cell.
- R3: An instruction word is 40 bits. Bits 39:32 hold the opcode, bits 31:16 hold address field A, and bits 15:0 hold address field B. Only the low 8 bits of each address field select a cell. The upper 8 bits are ignored.
- R4: Opcode 1 (load) copies cell A into `workReg`. `workReg` takes the new value 7 clock edges after the instruction's first cycle, and the next instruction starts on the edge after that.
- R5: Opcode 2 (compare) compares cell A with cell B as unsigned 40-bit values. It then sets `flags` to 3'b100 (A greater), 3'b010 (equal) or 3'b001 (A less), so exactly one bit is set. The result appears after 9 edges, and the instruction takes 9 cycles.
- R6: Opcode 9 (add) writes (cell A + cell B) mod 2^40 into cell B, and no other cell changes. The write lands on the 10th edge of the instruction. A and B may be the same cell.
- R7: Opcode 255 (halt) raises `halted` 4 edges after its first cycle. `halted` then stays high, and `flags`, `workReg` and memory stop changing.
- R8: Any other opcode raises both `halted` and `fault` 4 edges after its first cycle. Both stay high until reset.
- R9: Instructions run in order, from consecutive cells. An add that overwrites the cell of the next instruction is seen by that instruction's fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables the preload port |
| preWe | input | 1 | Preload write enable (honoured only while rst is high) |
| preAddr | input | 8 | Preload cell address |
| preData | input | 40 | Preload cell data |
| peekAddr | input | 8 | Cell address for the read-only peek port |
| peekData | output | 40 | Contents of cell peekAddr, combinational |
| halted | output | 1 | Core has stopped |
| fault | output | 1 | Core stopped on an unknown opcode |
| flags | output | 3 | Condition flags {greater, equal, less} |
| workReg | output | 40 | Working register written by load |

## Verification
An add's store and the fetch of the following instruction fall on neighbouring cycles and touch the same RAM. In one program an add writes into the cell that holds the next instruction, turning an illegal opcode into a load. The run passes only if the core loads the expected value and raises no fault. A second collision is an add whose two addresses are the same cell, so the read and the write-back target one word. A third drives preload writes while the core is running, and the affected cell is read back through the peek port after halt. A behavioural model in the bench advances with the clock and judges every cycle.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int DEF_WORD_W = 40;
  localparam int DEF_OP_W   = 8;
  localparam int DEF_AF_W   = 16;
  localparam int DEF_ADDR_W = 8;

  localparam logic [7:0] OP_LOAD = 8'd1;
  localparam logic [7:0] OP_CMP  = 8'd2;
  localparam logic [7:0] OP_ADD  = 8'd9;
  localparam logic [7:0] OP_HALT = 8'd255;

  // strobes from control to datapath, at most a few per cycle
  typedef struct packed {
    logic marFromPc;
    logic marFromA;
    logic marFromB;
    logic fetch;
    logic store;
    logic irLoad;
    logic pcInc;
    logic tmpLoad;
    logic rLoad;
    logic mdrSum;
    logic ccrLoad;
  } ctlStrobe_t;

  typedef enum logic [3:0] {
    S_F1, S_F2, S_F3, S_DEC,
    S_OP1, S_OP2, S_LOADR,
    S_OP3, S_OP4, S_CMPF,
    S_SUM, S_STORE, S_HALT
  } ctlState_t;
endpackage

// File: rtl/mm_ram.sv
module mm_ram #(
  parameter int WORD_W = mm_pkg::DEF_WORD_W,
  parameter int ADDR_W = mm_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [WORD_W-1:0] wData,
  input  logic [ADDR_W-1:0] rAddr,
  output logic [WORD_W-1:0] rData,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [WORD_W-1:0] peekData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[wAddr] <= wData;
  end

  // read data is captured by the data register downstream
  assign rData    = cells[rAddr];
  assign peekData = cells[peekAddr];
endmodule

// File: rtl/mm_datapath.sv
module mm_datapath
  import mm_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int OP_W   = DEF_OP_W,
  parameter int AF_W   = DEF_AF_W,
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        ctl,
  input  logic [WORD_W-1:0] memRd,
  output logic [ADDR_W-1:0] marOut,
  output logic [WORD_W-1:0] mdrOut,
  output logic [OP_W-1:0]   opcode,
  output logic [WORD_W-1:0] workReg,
  output logic [2:0]        flags
);
  localparam int FB_LO = 0;
  localparam int FA_LO = AF_W;
  localparam int OP_LO = 2 * AF_W;

  logic [ADDR_W-1:0] pc, mar;
  logic [WORD_W-1:0] mdr, ir, tmp, rReg;
  logic [2:0]        ccr;
  logic [WORD_W-1:0] sum;
  logic              aGt, aEq, aLt;

  assign sum = tmp + mdr;
  assign aGt = tmp > mdr;
  assign aEq = tmp == mdr;
  assign aLt = tmp < mdr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      mar  <= '0;
      mdr  <= '0;
      ir   <= '0;
      tmp  <= '0;
      rReg <= '0;
      ccr  <= '0;
    end else begin
      if (ctl.marFromPc)     mar <= pc;
      else if (ctl.marFromA) mar <= ir[FA_LO +: ADDR_W];
      else if (ctl.marFromB) mar <= ir[FB_LO +: ADDR_W];

      if (ctl.fetch)       mdr <= memRd;
      else if (ctl.mdrSum) mdr <= sum;

      if (ctl.irLoad)  ir   <= mdr;
      if (ctl.pcInc)   pc   <= pc + 1'b1;
      if (ctl.tmpLoad) tmp  <= mdr;
      if (ctl.rLoad)   rReg <= mdr;
      if (ctl.ccrLoad) ccr  <= {aGt, aEq, aLt};
    end
  end

  assign marOut  = mar;
  assign mdrOut  = mdr;
  assign opcode  = ir[OP_LO +: OP_W];
  assign workReg = rReg;
  assign flags   = ccr;
endmodule

// File: rtl/mm_control.sv
module mm_control
  import mm_pkg::*;
#(
  parameter int OP_W = DEF_OP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output ctlStrobe_t      ctl,
  output logic            halted,
  output logic            fault
);
  ctlState_t state, nxt;
  logic      faultR;
  logic      known;

  assign known = (opcode == OP_LOAD) || (opcode == OP_CMP) ||
                 (opcode == OP_ADD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_F1;
      faultR <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_DEC && !known && opcode != OP_HALT) faultR <= 1'b1;
    end
  end

  always_comb begin
    ctl = '0;
    nxt = state;
    case (state)
      S_F1:    begin ctl.marFromPc = 1'b1; nxt = S_F2; end
      S_F2:    begin ctl.fetch = 1'b1; nxt = S_F3; end
      S_F3:    begin ctl.irLoad = 1'b1; ctl.pcInc = 1'b1; nxt = S_DEC; end
      S_DEC:   nxt = known ? S_OP1 : S_HALT;
      S_OP1:   begin ctl.marFromA = 1'b1; nxt = S_OP2; end
      S_OP2:   begin
                 ctl.fetch = 1'b1;
                 nxt = (opcode == OP_LOAD) ? S_LOADR : S_OP3;
               end
      S_LOADR: begin ctl.rLoad = 1'b1; nxt = S_F1; end
      S_OP3:   begin ctl.tmpLoad = 1'b1; ctl.marFromB = 1'b1; nxt = S_OP4; end
      S_OP4:   begin
                 ctl.fetch = 1'b1;
                 nxt = (opcode == OP_CMP) ? S_CMPF : S_SUM;
               end
      S_CMPF:  begin ctl.ccrLoad = 1'b1; nxt = S_F1; end
      S_SUM:   begin ctl.mdrSum = 1'b1; nxt = S_STORE; end
      S_STORE: begin ctl.store = 1'b1; nxt = S_F1; end
      S_HALT:  nxt = S_HALT;
      default: nxt = S_F1;
    endcase
  end

  assign halted = (state == S_HALT);
  assign fault  = faultR;
endmodule

// File: rtl/mm_core.sv
module mm_core
  import mm_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int OP_W   = DEF_OP_W,
  parameter int AF_W   = DEF_AF_W,
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              preWe,
  input  logic [ADDR_W-1:0] preAddr,
  input  logic [WORD_W-1:0] preData,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [WORD_W-1:0] peekData,
  output logic              halted,
  output logic              fault,
  output logic [2:0]        flags,
  output logic [WORD_W-1:0] workReg
);
  ctlStrobe_t        ctl;
  logic [ADDR_W-1:0] mar;
  logic [WORD_W-1:0] mdr, memRd;
  logic [OP_W-1:0]   opcode;
  logic              memWe;
  logic [ADDR_W-1:0] memWAddr;
  logic [WORD_W-1:0] memWData;

  // preload owns the write port during reset, the core afterwards
  assign memWe    = rst ? preWe   : ctl.store;
  assign memWAddr = rst ? preAddr : mar;
  assign memWData = rst ? preData : mdr;

  mm_ram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) uRam (
    .clk(clk), .we(memWe), .wAddr(memWAddr), .wData(memWData),
    .rAddr(mar), .rData(memRd), .peekAddr(peekAddr), .peekData(peekData)
  );

  mm_datapath #(.WORD_W(WORD_W), .OP_W(OP_W), .AF_W(AF_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rst(rst), .ctl(ctl), .memRd(memRd), .marOut(mar),
    .mdrOut(mdr), .opcode(opcode), .workReg(workReg), .flags(flags)
  );

  mm_control #(.OP_W(OP_W)) uCtl (
    .clk(clk), .rst(rst), .opcode(opcode), .ctl(ctl),
    .halted(halted), .fault(fault)
  );
endmodule

// File: rtl/mm_core_chk.sv
module mm_core_chk
  import mm_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W
) (
  input logic              clk,
  input logic              rst,
  input logic              halted,
  input logic              fault,
  input logic [2:0]        flags,
  input logic [WORD_W-1:0] workReg,
  input ctlStrobe_t        ctl
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!halted && !fault && flags == 3'b000));

  // R4
  rload_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(workReg) |-> $past(ctl.rLoad));

  // R5
  flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flags));

  // R5
  flags_written_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ctl.ccrLoad) |-> ($countones(flags) == 1));

  // R6
  store_after_sum_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.store |-> $past(ctl.mdrSum));

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(flags) && $stable(workReg)));

  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!ctl.store && !ctl.fetch));

  // R8
  fault_halts_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> halted);
endmodule

bind mm_core mm_core_chk #(.WORD_W(WORD_W)) uChk (
  .clk(clk), .rst(rst), .halted(halted), .fault(fault),
  .flags(flags), .workReg(workReg), .ctl(ctl)
);

// File: tb/mm_core_test.sv
module mm_core_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        preWe = 1'b0;
  logic [7:0]  preAddr = '0;
  logic [39:0] preData = '0;
  logic [7:0]  peekAddr = '0;
  logic [39:0] peekData;
  logic        halted, fault;
  logic [2:0]  flags;
  logic [39:0] workReg;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [39:0] img [256];
  logic [39:0] m [256];
  logic [7:0]  pcM;
  logic [39:0] rM, insM;
  logic [2:0]  flagsM;
  logic        haltM, faultM;
  int          k, dur;

  mm_core uut (
    .clk(clk), .rst(rst), .preWe(preWe), .preAddr(preAddr), .preData(preData),
    .peekAddr(peekAddr), .peekData(peekData), .halted(halted), .fault(fault),
    .flags(flags), .workReg(workReg)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles > 150000);
    bad++; total++;
    $display("FAIL watchdog: got %0d cycles exp fewer than 150000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [39:0] ins(input logic [7:0] op, input logic [15:0] a, input logic [15:0] b);
    return {op, a, b};
  endfunction

  task automatic check(input string req, input logic [39:0] got, input logic [39:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic peek(input logic [7:0] a, output logic [39:0] v);
    peekAddr = a;
    #1;
    v = peekData;
  endtask

  // behavioural model: one step per rising edge
  task automatic modelStep();
    logic [7:0] op, a, b;
    if (haltM) return;
    if (k == 0) begin
      insM = m[pcM];
      pcM  = pcM + 8'd1;
      case (insM[39:32])
        8'd1: dur = 7;
        8'd2: dur = 9;
        8'd9: dur = 10;
        default: dur = 4;
      endcase
    end
    k++;
    op = insM[39:32];
    a  = insM[23:16];
    b  = insM[7:0];
    if (op == 8'd1 && k == 7) rM = m[a];
    if (op == 8'd2 && k == 9)
      flagsM = (m[a] > m[b]) ? 3'b100 : (m[a] == m[b]) ? 3'b010 : 3'b001;
    if (op == 8'd9 && k == 10) m[b] = m[a] + m[b];
    if (op != 8'd1 && op != 8'd2 && op != 8'd9 && k == 4) begin
      haltM  = 1'b1;
      faultM = (op != 8'd255);
    end
    if (k == dur) k = 0;
  endtask

  task automatic runProg(input bit poke);
    logic [39:0] v;
    int n;
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      preWe = 1'b1; preAddr = 8'(i); preData = img[i];
      m[i] = img[i];
    end
    @(negedge clk);
    preWe = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 halted", {39'd0, halted}, 40'd0);
    check("R1 fault", {39'd0, fault}, 40'd0);
    check("R1 flags", {37'd0, flags}, 40'd0);
    check("R1 workReg", workReg, 40'd0);
    pcM = 0; rM = 0; flagsM = 0; haltM = 0; faultM = 0; k = 0; dur = 0;
    rst = 1'b0;
    n = 0;
    while (!(haltM && n > 6) && n < 5000) begin
      @(posedge clk);
      modelStep();
      @(negedge clk);
      n++;
      if (poke && n >= 2 && n <= 8) begin
        preWe = 1'b1; preAddr = 8'd30; preData = 40'hDE_AD00_BEEF;
      end else preWe = 1'b0;
      check("R4 workReg per cycle", workReg, rM);
      check("R5 flags per cycle", {37'd0, flags}, {37'd0, flagsM});
      check("R7 halted per cycle", {39'd0, halted}, {39'd0, haltM});
      check("R8 fault per cycle", {39'd0, fault}, {39'd0, faultM});
    end
    preWe = 1'b0;
    for (int i = 0; i < 256; i++) begin
      peek(8'(i), v);
      check("R6 memory image", v, m[i]);
    end
  endtask

  initial begin
    logic [39:0] v;
    // program 1: load, compare, add, equal compare, halt
    for (int i = 0; i < 256; i++) img[i] = '0;
    img[0]  = ins(8'd1, 16'h1228, 16'h0000);   // R3 upper address bits ignored -> cell 40
    img[1]  = ins(8'd2, 16'd40, 16'd41);
    img[2]  = ins(8'd9, 16'd40, 16'd41);
    img[3]  = ins(8'd2, 16'd42, 16'hAB2B);     // cell 43
    img[4]  = ins(8'd255, 16'd0, 16'd0);
    img[40] = 40'd100; img[41] = 40'd7; img[42] = 40'd5; img[43] = 40'd5;
    runProg(1'b0);
    check("R4 load value", workReg, 40'd100);
    check("R5 equal flags", {37'd0, flags}, 40'b010);
    peek(8'd41, v); check("R6 add result", v, 40'd107);
    peek(8'd40, v); check("R6 operand A kept", v, 40'd100);
    check("R7 halted", {39'd0, halted}, 40'd1);
    check("R8 no fault on halt", {39'd0, fault}, 40'd0);
    check("R3 high address bits", workReg, 40'd100);

    // program 2: unsigned less, wrap, same-cell add, self-modify, bad opcode
    for (int i = 0; i < 256; i++) img[i] = '0;
    img[0]  = ins(8'd2, 16'd50, 16'd51);
    img[1]  = ins(8'd9, 16'd50, 16'd51);
    img[2]  = ins(8'd9, 16'd52, 16'd52);
    img[3]  = ins(8'd9, 16'd53, 16'd4);
    img[4]  = ins(8'd0, 16'd54, 16'd0);        // becomes load 54
    img[5]  = ins(8'd7, 16'd0, 16'd0);
    img[50] = 40'd3; img[51] = 40'hFF_FFFF_FFFF; img[52] = 40'd6;
    img[53] = 40'h01_0000_0000; img[54] = 40'h00_0001_2345;
    runProg(1'b0);
    check("R5 unsigned less flags", {37'd0, flags}, 40'b001);
    peek(8'd51, v); check("R6 wrap add", v, 40'd2);
    peek(8'd52, v); check("R6 same-cell add", v, 40'd12);
    peek(8'd4, v);  check("R9 rewritten instruction", v, ins(8'd1, 16'd54, 16'd0));
    check("R9 modified instruction executed", workReg, 40'h00_0001_2345);
    check("R8 fault", {39'd0, fault}, 40'd1);
    check("R8 halted", {39'd0, halted}, 40'd1);

    // program 3: preload writes during run are ignored; greater compare
    for (int i = 0; i < 256; i++) img[i] = '0;
    img[0]  = ins(8'd1, 16'd30, 16'd0);
    img[1]  = ins(8'd2, 16'd30, 16'd31);
    img[2]  = ins(8'd255, 16'd0, 16'd0);
    img[30] = 40'd77; img[31] = 40'd1;
    runProg(1'b1);
    peek(8'd30, v); check("R2 preload ignored while running", v, 40'd77);
    check("R2 load sees original", workReg, 40'd77);
    check("R5 greater flags", {37'd0, flags}, 40'b100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule